// File: doc/BRIEF.md
# Instruction Reuse Buffer

A set-associative store of completed instruction results, keyed by instruction address. When an instruction is about to issue, the lookup port gets its address, its two source register names and an inputs-ready flag. The port reports a hit, with the stored result and the way that holds it, only when a resident entry passes a non-speculative reuse test. An execution that gets a hit can skip the execute stage and commit the stored result.

Results enter through an insert port. The port carries the address, the source register names, the result and, if the instruction consumed a value from an earlier buffered instruction, a link (set and way) to that producer entry. The insert port reports the way it chose, so a caller can link later entries to it. A register-write port broadcasts each destination register number. Every entry that reads that register loses its validity.

Entries form dependence chains. An entry with a link may be reused only after the entry it points to has itself been reused, so a chain is consumed in order. Each entry keeps a reused flag. The flag is set on a hit, and it is cleared when the entry is invalidated or rewritten.

Top module: `reuse_buf`

## Requirements
- R1: A lookup with the ready flag high hits and returns the stored result in the same cycle when an entry is valid, its address matches, and both of its source register names equal the presented ones. The set index is address bits [IDX_W+1:2].
- R2: A lookup whose source register names differ from the stored ones misses, even when the address matches.
- R3: A lookup with the ready flag low misses.
- R4: A register write of register r makes every entry that has r as either source invalid from the next cycle on.
- R5: When a register write and a lookup fall in the same cycle, the write is applied first: a lookup of an entry that reads the written register misses in that cycle.
- R6: A lookup hit sets the entry's reused flag. An entry inserted with a link hits only while the linked producer entry has its reused flag set.
- R7: A producer's reused flag is cleared when the producer is invalidated or rewritten. Its dependents then miss until it is reused again.
- R8: An insert of an address that is not resident takes the lowest-numbered invalid way of its set and reports it on ins_way. A new entry starts with its reused flag clear.
- R9: An insert into a full set replaces the least recently used way. Both inserts and lookup hits count as a use.
- R10: An insert of an address that is already resident and valid rewrites the same way.
- R11: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | input | 1 | Source operands ready for the reuse test |
| lk_pc | input | ADDR_W | Lookup instruction address |
| lk_src_a | input | REG_W | First source register name |
| lk_src_b | input | REG_W | Second source register name |
| lk_hit | output | 1 | Reuse test passed |
| lk_way | output | WAY_W | Way that hit |
| lk_result | output | DATA_W | Stored result of the hitting way |
| ins_valid | input | 1 | Insert request |
| ins_pc | input | ADDR_W | Insert instruction address |
| ins_src_a | input | REG_W | First source register name to store |
| ins_src_b | input | REG_W | Second source register name to store |
| ins_result | input | DATA_W | Result to store |
| ins_linked | input | 1 | Entry depends on a buffered producer |
| ins_link_set | input | IDX_W | Producer set |
| ins_link_way | input | WAY_W | Producer way |
| ins_way | output | WAY_W | Way chosen for the insert |
| wr_en | input | 1 | Register write broadcast |
| wr_reg | input | REG_W | Register number being written |

## Verification
Register-write invalidation and the lookup reuse test can fall in the same cycle. The bench provokes this by presenting a lookup of a resident, otherwise hitting entry while it broadcasts one of that entry's source registers. It expects a miss in that cycle and a miss again in the next cycle, which shows that the invalidation was also stored. A second collision is a producer being invalidated after it was reused. This is judged by a dependent that hit before the invalidation and misses after it.

// File: rtl/reuse_buf.sv
module reuse_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic [REG_W-1:0]  lk_src_a,
  input  logic [REG_W-1:0]  lk_src_b,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [DATA_W-1:0] lk_result,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_pc,
  input  logic [REG_W-1:0]  ins_src_a,
  input  logic [REG_W-1:0]  ins_src_b,
  input  logic [DATA_W-1:0] ins_result,
  input  logic              ins_linked,
  input  logic [IDX_W-1:0]  ins_link_set,
  input  logic [WAY_W-1:0]  ins_link_way,
  output logic [WAY_W-1:0]  ins_way,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_reg
);

  logic [SETS-1:0][WAYS-1:0] vld, rsd, kill;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [REG_W-1:0]  sa_q   [SETS][WAYS];
  logic [REG_W-1:0]  sb_q   [SETS][WAYS];
  logic [DATA_W-1:0] res_q  [SETS][WAYS];
  logic              lnk_q  [SETS][WAYS];
  logic [IDX_W-1:0]  lset_q [SETS][WAYS];
  logic [WAY_W-1:0]  lway_q [SETS][WAYS];
  logic [WAY_W-1:0]  age_q  [SETS][WAYS];

  wire [IDX_W-1:0] lk_set = lk_pc[IDX_W+1:2];
  wire [TAG_W-1:0] lk_tag = lk_pc[ADDR_W-1:IDX_W+2];
  wire [IDX_W-1:0] is_set = ins_pc[IDX_W+1:2];
  wire [TAG_W-1:0] is_tag = ins_pc[ADDR_W-1:IDX_W+2];

  logic [WAYS-1:0] hv, tm, fr;

  always_comb begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        kill[s][w] = wr_en && (sa_q[s][w] == wr_reg || sb_q[s][w] == wr_reg);
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hv[w] = lk_valid && lk_ready && vld[lk_set][w] && !kill[lk_set][w]
           && tag_q[lk_set][w] == lk_tag
           && sa_q[lk_set][w] == lk_src_a && sb_q[lk_set][w] == lk_src_b
           && (!lnk_q[lk_set][w]
               || (rsd[lset_q[lk_set][w]][lway_q[lk_set][w]]
                   && !kill[lset_q[lk_set][w]][lway_q[lk_set][w]]));
      if (hv[w]) lk_way = WAY_W'(w);
    end
  end

  assign lk_hit    = |hv;
  assign lk_result = res_q[lk_set][lk_way];

  always_comb begin
    ins_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      tm[w] = vld[is_set][w] && tag_q[is_set][w] == is_tag;
      fr[w] = !vld[is_set][w];
    end
    if (|tm) begin
      for (int w = 0; w < WAYS; w++) if (tm[w]) ins_way = WAY_W'(w);
    end else if (|fr) begin
      for (int w = WAYS-1; w >= 0; w--) if (fr[w]) ins_way = WAY_W'(w);
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[is_set][w] == WAY_W'(WAYS-1)) ins_way = WAY_W'(w);
    end
  end

  wire             touch = ins_valid || lk_hit;
  wire [IDX_W-1:0] t_set = ins_valid ? is_set : lk_set;
  wire [WAY_W-1:0] t_way = ins_valid ? ins_way : lk_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rsd <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w]  <= WAY_W'(w);
          tag_q[s][w]  <= '0;
          sa_q[s][w]   <= '0;
          sb_q[s][w]   <= '0;
          res_q[s][w]  <= '0;
          lnk_q[s][w]  <= 1'b0;
          lset_q[s][w] <= '0;
          lway_q[s][w] <= '0;
        end
    end else begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (kill[s][w]) begin
            vld[s][w] <= 1'b0;
            rsd[s][w] <= 1'b0;
          end
      if (lk_hit) rsd[lk_set][lk_way] <= 1'b1;
      if (touch)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == t_way) age_q[t_set][w] <= '0;
          else if (age_q[t_set][w] < age_q[t_set][t_way])
            age_q[t_set][w] <= age_q[t_set][w] + 1'b1;
      if (ins_valid) begin
        vld[is_set][ins_way]    <= 1'b1;
        rsd[is_set][ins_way]    <= 1'b0;
        tag_q[is_set][ins_way]  <= is_tag;
        sa_q[is_set][ins_way]   <= ins_src_a;
        sb_q[is_set][ins_way]   <= ins_src_b;
        res_q[is_set][ins_way]  <= ins_result;
        lnk_q[is_set][ins_way]  <= ins_linked;
        lset_q[is_set][ins_way] <= ins_link_set;
        lway_q[is_set][ins_way] <= ins_link_way;
      end
    end
  end

  a_r3_hit_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid && lk_ready);

  a_r1_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hv));

  a_r6_hit_marks_reused: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && !ins_valid |=> rsd[$past(lk_set)][$past(lk_way)]);

  a_r8_insert_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> vld[$past(is_set)][$past(ins_way)] && !rsd[$past(is_set)][$past(ins_way)]);

  a_r9_insert_is_mru: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> age_q[$past(is_set)][$past(ins_way)] == '0);

endmodule

// File: tb/reuse_buf_tb.sv
module reuse_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 77;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid, lk_ready, lk_hit;
  logic [31:0] lk_pc, lk_result, ins_pc, ins_result;
  logic [4:0] lk_src_a, lk_src_b, ins_src_a, ins_src_b, wr_reg;
  logic [1:0] lk_way, ins_way, ins_link_way;
  logic ins_valid, ins_linked, wr_en;
  logic [3:0] ins_link_set;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reuse_buf dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .lk_src_a(lk_src_a), .lk_src_b(lk_src_b),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_result(lk_result),
    .ins_valid(ins_valid), .ins_pc(ins_pc), .ins_src_a(ins_src_a),
    .ins_src_b(ins_src_b), .ins_result(ins_result), .ins_linked(ins_linked),
    .ins_link_set(ins_link_set), .ins_link_way(ins_link_way), .ins_way(ins_way),
    .wr_en(wr_en), .wr_reg(wr_reg)
  );

  // vector: op(2) pc(32) a(5) b(5) value(32) exp_hit(1); op 0=insert 1=lookup 2=regwrite
  localparam logic [VW-1:0] VEC [10] = '{
    {2'd0, 32'h100, 5'd1, 5'd2, 32'hAAAA, 1'b0},
    {2'd1, 32'h100, 5'd1, 5'd2, 32'hAAAA, 1'b1},
    {2'd1, 32'h100, 5'd1, 5'd3, 32'h0,    1'b0},
    {2'd1, 32'h140, 5'd1, 5'd2, 32'h0,    1'b0},
    {2'd0, 32'h104, 5'd3, 5'd4, 32'hBBBB, 1'b0},
    {2'd2, 32'h0,   5'd2, 5'd0, 32'h0,    1'b0},
    {2'd1, 32'h100, 5'd1, 5'd2, 32'h0,    1'b0},
    {2'd1, 32'h104, 5'd3, 5'd4, 32'hBBBB, 1'b1},
    {2'd0, 32'h100, 5'd1, 5'd2, 32'hCCCC, 1'b0},
    {2'd1, 32'h100, 5'd1, 5'd2, 32'hCCCC, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic idle_in();
    lk_valid = 0; lk_ready = 0; lk_pc = 0; lk_src_a = 0; lk_src_b = 0;
    ins_valid = 0; ins_pc = 0; ins_src_a = 0; ins_src_b = 0; ins_result = 0;
    ins_linked = 0; ins_link_set = 0; ins_link_way = 0; wr_en = 0; wr_reg = 0;
  endtask

  task automatic ins(input logic [31:0] pc, input logic [4:0] a, b,
                     input logic [31:0] v, input logic lk, input logic [3:0] ls,
                     input logic [1:0] lw, output logic [1:0] way);
    @(negedge clk); idle_in();
    ins_valid = 1; ins_pc = pc; ins_src_a = a; ins_src_b = b; ins_result = v;
    ins_linked = lk; ins_link_set = ls; ins_link_way = lw;
    #1 way = ins_way;
  endtask

  task automatic look(input logic [31:0] pc, input logic [4:0] a, b, input logic rdy,
                      input logic wr, input logic [4:0] r,
                      output logic hit, output logic [31:0] res);
    @(negedge clk); idle_in();
    lk_valid = 1; lk_ready = rdy; lk_pc = pc; lk_src_a = a; lk_src_b = b;
    wr_en = wr; wr_reg = r;
    #1 hit = lk_hit; res = lk_result;
  endtask

  task automatic regw(input logic [4:0] r);
    @(negedge clk); idle_in(); wr_en = 1; wr_reg = r;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic h; logic [31:0] r; logic [1:0] w, wp;
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R11: nothing resident after reset
    look(32'h100, 5'd1, 5'd2, 1, 0, 0, h, r);
    chk("R11 reset miss", {31'b0, h}, 0);

    // table: R1 R2 R4 R10-refill
    for (int i = 0; i < 10; i++) begin
      logic [VW-1:0] v = VEC[i];
      case (v[76:75])
        2'd0: ins(v[74:43], v[42:38], v[37:33], v[32:1], 0, 0, 0, w);
        2'd2: regw(v[42:38]);
        default: begin
          look(v[74:43], v[42:38], v[37:33], 1, 0, 0, h, r);
          chk($sformatf("R1/R2/R4 vec%0d hit", i), {31'b0, h}, {31'b0, v[0]});
          if (v[0]) chk($sformatf("R1 vec%0d result", i), r, v[32:1]);
        end
      endcase
    end

    // R3: ready low
    ins(32'h200, 5'd5, 5'd6, 32'h5151, 0, 0, 0, w);
    look(32'h200, 5'd5, 5'd6, 0, 0, 0, h, r);
    chk("R3 not ready miss", {31'b0, h}, 0);
    look(32'h200, 5'd5, 5'd6, 1, 0, 0, h, r);
    chk("R3 ready hit", {31'b0, h}, 1);

    // R5: same-cycle write then lookup
    look(32'h200, 5'd5, 5'd6, 1, 1, 5'd6, h, r);
    chk("R5 same-cycle miss", {31'b0, h}, 0);
    look(32'h200, 5'd5, 5'd6, 1, 0, 0, h, r);
    chk("R5 R4 stays invalid", {31'b0, h}, 0);

    // R6 R7: chain order
    ins(32'h300, 5'd7, 5'd8, 32'h3000, 0, 0, 0, wp);
    ins(32'h304, 5'd9, 5'd10, 32'h3004, 1, 4'h0, wp, w);
    look(32'h304, 5'd9, 5'd10, 1, 0, 0, h, r);
    chk("R6 dependent before producer", {31'b0, h}, 0);
    look(32'h300, 5'd7, 5'd8, 1, 0, 0, h, r);
    chk("R6 producer hit", {31'b0, h}, 1);
    look(32'h304, 5'd9, 5'd10, 1, 0, 0, h, r);
    chk("R6 dependent after producer", {31'b0, h}, 1);
    chk("R6 dependent result", r, 32'h3004);
    regw(5'd7);
    look(32'h304, 5'd9, 5'd10, 1, 0, 0, h, r);
    chk("R7 producer invalidated", {31'b0, h}, 0);
    ins(32'h300, 5'd7, 5'd8, 32'h3000, 0, 0, 0, w);
    chk("R7 refill same way", {30'b0, w}, {30'b0, wp});
    look(32'h304, 5'd9, 5'd10, 1, 0, 0, h, r);
    chk("R7 refilled producer not reused", {31'b0, h}, 0);

    // R8 R9 R10: set 5
    for (int k = 0; k < 4; k++) begin
      ins(32'h14 + 32'(k) * 32'h40, 5'd11, 5'd12, 32'h500 + 32'(k), 0, 0, 0, w);
      chk($sformatf("R8 free way %0d", k), {30'b0, w}, 32'(k));
    end
    look(32'h14, 5'd11, 5'd12, 1, 0, 0, h, r);
    chk("R9 touch A", {31'b0, h}, 1);
    ins(32'h114, 5'd11, 5'd12, 32'h504, 0, 0, 0, w);
    chk("R9 victim is LRU way", {30'b0, w}, 1);
    look(32'h54, 5'd11, 5'd12, 1, 0, 0, h, r);
    chk("R9 evicted miss", {31'b0, h}, 0);
    look(32'h114, 5'd11, 5'd12, 1, 0, 0, h, r);
    chk("R9 new entry result", r, 32'h504);
    ins(32'h14, 5'd11, 5'd12, 32'h5AAA, 0, 0, 0, w);
    chk("R10 resident same way", {30'b0, w}, 0);
    look(32'h14, 5'd11, 5'd12, 1, 0, 0, h, r);
    chk("R10 rewritten result", r, 32'h5AAA);

    @(negedge clk); idle_in();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule